// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This block is an SPI master controller attached to a small memory-mapped register bus. Software sets the clock mode, bit order and bit rate through registers, then writes one byte to the data register. That write starts an 8-bit full-duplex exchange on SCK/MOSI/MISO. The byte received from the slave is read back from the same data register address.

Status flags report three events: the end of an exchange, a data write made while an exchange is still running, and a bus conflict seen on the slave-select input. Completion and conflict each drive their own interrupt line. An 8-bit general-purpose port supplies the slave-select output on bit 3. The divider uses a prescale field and a power-of-two field, so one byte sets a wide range of bit rates.

Top module: `spi_master_periph`

## Requirements
- R1: After reset the port direction register reads 0x0E, the port data register reads 0x08 (bit 3, the active-low slave select, is high), control and status read 0x00, and SCK is low.
- R2: Registers sit at these offsets: control 0x00, auxiliary control 0x01, rate 0x04, status 0x05, data 0x09, port data 0x0D and port direction 0x10. The rate register keeps only bits 6:4 and 2:0, and the other bits read as 0.
- R3: A data write starts an exchange only when control bit 6 (enable) and bit 4 (master) are both set and no exchange is running. Otherwise SCK stays at its idle level and no flag changes.
- R4: Each SCK half period lasts (P+1)·2^E bus cycles, where P is rate bits 6:4 and E is rate bits 2:0. The smallest ratio is a divide by 2. The completion flag becomes visible 16·(P+1)·2^E+1 cycles after the data write edge.
- R5: SCK idles at control bit 3. With control bit 2 clear, the first MOSI bit is valid before the first SCK edge, and each bit is sampled on the odd-numbered SCK edges (1st, 3rd and so on). With bit 2 set, each bit is driven on the odd-numbered edges and sampled on the even-numbered edges.
- R6: Control bit 0 set sends and receives the least significant bit first. Clear, the most significant bit goes first.
- R7: Status bit 7 is set when an exchange ends. A status read that sees bit 7 or bit 6 set, followed by a data read, clears both bits. A data read with no such status read leaves them set. irq_xfer_o equals control bit 7 AND status bit 7.
- R8: A data write during an exchange sets status bit 6. The byte being shifted is not changed by that write.
- R9: When control bits 6 and 4 are set, control bit 1 is clear and ss_in_ni is low, status bit 4 is set, control bits 6 and 4 are cleared, and any running exchange stops with SCK back at its idle level. irq_modf_o equals control bit 7 AND status bit 4. Bit 4 clears when a status read that saw it set is followed by a write to the control register.
- R10: With control bit 1 set, a low ss_in_ni raises no fault.
- R11: port_o mirrors the port data register, and port_oe_o mirrors the port direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (triggers read side effects) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_in_ni | input | 1 | Slave-select sense input for fault detection |
| port_o | output | 8 | Port data, bit 3 is the slave select |
| port_oe_o | output | 8 | Port output enables |
| irq_xfer_o | output | 1 | Completion interrupt |
| irq_modf_o | output | 1 | Mode-fault interrupt |

## Verification
The assertions check, on every cycle, the local cause-and-effect rules. An enabled idle data write starts the shifter. A write during an exchange raises the collision flag. A fault stops the shifter and drops the enables. A qualified data read clears completion. SCK holds still between divider ticks. Only the bench scenarios, with a behavioural slave, can show the correct bit order and sampling edge in all four clock modes, the exact cycle count for each rate setting, and that a byte keeps its value when a collision occurs.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int ADDR_W = 5;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_CTRL  = 5'h00;
  localparam addr_t A_AUX   = 5'h01;
  localparam addr_t A_RATE  = 5'h04;
  localparam addr_t A_STAT  = 5'h05;
  localparam addr_t A_DATA  = 5'h09;
  localparam addr_t A_PORT  = 5'h0D;
  localparam addr_t A_PDIR  = 5'h10;

  // control bit positions
  localparam int C_IE   = 7;
  localparam int C_EN   = 6;
  localparam int C_MSTR = 4;
  localparam int C_CPOL = 3;
  localparam int C_CPHA = 2;
  localparam int C_SSOE = 1;
  localparam int C_LSB  = 0;
endpackage

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
  parameter int PRE_W = 3,
  parameter int POW_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [POW_W-1:0] pow_i,
  output logic             tick_o
);
  localparam int CNT_W = PRE_W + (1 << POW_W);

  logic [CNT_W-1:0] half, cnt_q;

  assign half   = (CNT_W'(pre_i) + CNT_W'(1)) << pow_i;
  assign tick_o = run_i && (cnt_q == half - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              lsb_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              sck_o,
  output logic              mosi_o
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

  logic              busy_q, done_q, sck_q, mosi_q;
  logic [EW-1:0]     edge_q;
  logic [DATA_W-1:0] sr_q, sr_in;
  logic              out_bit;

  assign out_bit = lsb_i ? sr_q[0] : sr_q[DATA_W-1];
  assign sr_in   = lsb_i ? {miso_i, sr_q[DATA_W-1:1]} : {sr_q[DATA_W-2:0], miso_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; done_q <= 1'b0; sck_q <= 1'b0; mosi_q <= 1'b0;
      edge_q <= '0;   sr_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
      end else if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        edge_q <= '0;
        sr_q   <= tx_i;
        sck_q  <= cpol_i;
        if (!cpha_i) mosi_o_load(tx_i);
      end else if (busy_q && tick_i) begin
        sck_q  <= ~sck_q;
        edge_q <= edge_q + EW'(1);
        if (edge_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
        if (!edge_q[0]) begin            // leading edges
          if (cpha_i) mosi_q <= out_bit;
          else        sr_q   <= sr_in;
        end else begin                   // trailing edges
          if (cpha_i)              sr_q   <= sr_in;
          else if (edge_q != LAST) mosi_q <= out_bit;
        end
      end
    end
  end

  task automatic mosi_o_load(input logic [DATA_W-1:0] d);
    mosi_q <= lsb_i ? d[0] : d[DATA_W-1];
  endtask

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = sr_q;
  assign sck_o  = busy_q ? sck_q : cpol_i;
  assign mosi_o = mosi_q;

  // R4: SCK only moves on a divider tick
  a_r4_sck_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !tick_i && !abort_i |=> $stable(sck_q));
endmodule

// File: rtl/spi_master_periph.sv
module spi_master_periph import spi_pkg::*; #(
  parameter int         PRE_W    = 3,
  parameter int         POW_W    = 3,
  parameter logic [7:0] PDIR_RST = 8'h0E,
  parameter logic [7:0] PORT_RST = 8'h08
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              ss_in_ni,
  output logic [7:0]        port_o,
  output logic [7:0]        port_oe_o,
  output logic              irq_xfer_o,
  output logic              irq_modf_o
);
  localparam logic [7:0] RATE_MASK =
    (8'((1 << PRE_W) - 1) << 4) | 8'((1 << POW_W) - 1);

  logic [7:0] ctrl_q, aux_q, rate_q, port_q, pdir_q, rx_q;
  logic       spif_q, wcol_q, modf_q, arm_q, modf_arm_q;
  logic       busy, done, tick, start, fault_evt;
  logic [7:0] rx_sr;
  logic       wr_ctrl, wr_data, rd_stat, rd_data;

  assign wr_ctrl = wr_i && addr_i == A_CTRL;
  assign wr_data = wr_i && addr_i == A_DATA;
  assign rd_stat = rd_i && addr_i == A_STAT;
  assign rd_data = rd_i && addr_i == A_DATA;

  assign fault_evt = ctrl_q[C_EN] && ctrl_q[C_MSTR] && !ctrl_q[C_SSOE] && !ss_in_ni;
  assign start     = wr_data && ctrl_q[C_EN] && ctrl_q[C_MSTR] && !busy && !fault_evt;

  spi_clkdiv #(.PRE_W(PRE_W), .POW_W(POW_W)) u_div (
    .clk_i, .rst_ni, .run_i(busy),
    .pre_i(rate_q[4 +: PRE_W]), .pow_i(rate_q[0 +: POW_W]), .tick_o(tick));

  spi_shifter #(.DATA_W(8)) u_shf (
    .clk_i, .rst_ni, .start_i(start), .abort_i(fault_evt), .tx_i(wdata_i),
    .cpol_i(ctrl_q[C_CPOL]), .cpha_i(ctrl_q[C_CPHA]), .lsb_i(ctrl_q[C_LSB]),
    .tick_i(tick), .miso_i, .busy_o(busy), .done_o(done), .rx_o(rx_sr),
    .sck_o, .mosi_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0; aux_q <= '0; rate_q <= '0; rx_q <= '0;
      port_q <= PORT_RST; pdir_q <= PDIR_RST;
      spif_q <= 1'b0; wcol_q <= 1'b0; modf_q <= 1'b0;
      arm_q  <= 1'b0; modf_arm_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i;
      if (wr_i && addr_i == A_AUX)  aux_q  <= wdata_i;
      if (wr_i && addr_i == A_RATE) rate_q <= wdata_i & RATE_MASK;
      if (wr_i && addr_i == A_PORT) port_q <= wdata_i;
      if (wr_i && addr_i == A_PDIR) pdir_q <= wdata_i;

      if (rd_stat) begin
        arm_q      <= spif_q || wcol_q;
        modf_arm_q <= modf_q;
      end
      if (rd_data) begin
        if (arm_q) begin spif_q <= 1'b0; wcol_q <= 1'b0; end
        arm_q <= 1'b0;
      end
      if (wr_data && busy) wcol_q <= 1'b1;
      if (done) begin spif_q <= 1'b1; rx_q <= rx_sr; end

      if (wr_ctrl && modf_arm_q) begin modf_q <= 1'b0; modf_arm_q <= 1'b0; end
      if (fault_evt) begin
        modf_q         <= 1'b1;
        ctrl_q[C_EN]   <= 1'b0;
        ctrl_q[C_MSTR] <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_AUX:   rdata_o = aux_q;
      A_RATE:  rdata_o = rate_q;
      A_STAT:  rdata_o = {spif_q, wcol_q, 1'b0, modf_q, 4'b0};
      A_DATA:  rdata_o = rx_q;
      A_PORT:  rdata_o = port_q;
      A_PDIR:  rdata_o = pdir_q;
      default: rdata_o = 8'h00;
    endcase
  end

  assign port_o     = port_q;
  assign port_oe_o  = pdir_q;
  assign irq_xfer_o = ctrl_q[C_IE] && spif_q;
  assign irq_modf_o = ctrl_q[C_IE] && modf_q;

  a_r3_start_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy);
  a_r8_wcol_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data && busy |=> wcol_q);
  a_r9_fault_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_evt |=> !busy && modf_q && !ctrl_q[C_EN] && !ctrl_q[C_MSTR]);
  a_r7_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data && arm_q && !done |=> !spif_q && !wcol_q);
endmodule

// File: tb/spi_master_periph_bench.sv
module spi_master_periph_bench;
  logic clk = 0, rst_ni = 0;
  logic [4:0] addr = 0;
  logic wr = 0, rd = 0, miso = 0, ss_in_n = 1;
  logic [7:0] wdata = 0, rdata, port, port_oe;
  logic sck, mosi, irq_x, irq_m;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  spi_master_periph u_spi_master_periph (
    .clk_i(clk), .rst_ni, .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .ss_in_ni(ss_in_n),
    .port_o(port), .port_oe_o(port_oe), .irq_xfer_o(irq_x), .irq_modf_o(irq_m));

  // behavioural slave
  logic sl_en = 0, sl_cpha = 0, sl_lsb = 0;
  logic [7:0] sl_tx = 0, sl_rx = 0;
  int sl_e = 0;

  always @(sck) if (sl_en) begin
    #1;
    if ((sl_e % 2) == int'(sl_cpha)) begin
      if (sl_lsb) sl_rx[sl_e/2] = mosi; else sl_rx[7 - sl_e/2] = mosi;
    end else begin
      int k;
      k = sl_cpha ? sl_e/2 : sl_e/2 + 1;
      if (k < 8) miso = sl_lsb ? sl_tx[k] : sl_tx[7-k];
    end
    sl_e++;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bw(logic [4:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic br(logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic sl_start(logic cpha, logic lsb, logic [7:0] stx);
    sl_cpha = cpha; sl_lsb = lsb; sl_tx = stx; sl_rx = 0; sl_e = 0;
    if (!cpha) miso = lsb ? stx[0] : stx[7];
    sl_en = 1;
  endtask

  task automatic xfer(logic cpol, logic cpha, logic lsb, logic [7:0] rate,
                      logic [7:0] tx, logic [7:0] stx, output int cyc);
    bw(5'h00, {4'b1101, cpol, cpha, 1'b0, lsb});
    bw(5'h04, rate);
    sl_start(cpha, lsb, stx);
    bw(5'h09, tx);
    cyc = 0;
    while (!irq_x && cyc < 5000) begin @(negedge clk); cyc++; end
    sl_en = 0;
  endtask

  // {cpol, cpha, lsb, rate, tx, slave tx}
  localparam logic [26:0] VEC [0:5] = '{
    {3'b000, 8'h00, 8'hA5, 8'h3C},
    {3'b010, 8'h01, 8'h5A, 8'hC3},
    {3'b100, 8'h10, 8'h81, 8'h7E},
    {3'b110, 8'h21, 8'hF0, 8'h0F},
    {3'b001, 8'h02, 8'h01, 8'h80},
    {3'b111, 8'h00, 8'h96, 8'h69}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int cyc;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1 reset state
    br(5'h10, d); check("R1 pdir", d, 8'h0E);
    br(5'h0D, d); check("R1 port", d, 8'h08);
    br(5'h00, d); check("R1 ctrl", d, 8'h00);
    br(5'h05, d); check("R1 stat", d, 8'h00);
    check("R1 sck", sck, 0);
    check("R1 ss", port[3], 1);

    // R2 register map
    bw(5'h04, 8'hFF); br(5'h04, d); check("R2 rate mask", d, 8'h77);
    bw(5'h01, 8'h5A); br(5'h01, d); check("R2 aux", d, 8'h5A);

    // R11 port
    bw(5'h0D, 8'h00); @(negedge clk); check("R11 ss low", port[3], 0);
    bw(5'h10, 8'hFF); @(negedge clk); check("R11 oe", port_oe, 8'hFF);
    bw(5'h0D, 8'h08);

    // R3 disabled: write data ignored
    bw(5'h00, 8'h80); bw(5'h04, 8'h00); bw(5'h09, 8'h55);
    cyc = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (sck) cyc++; end
    check("R3 no sck", cyc, 0);
    br(5'h05, d); check("R3 no flag", d, 8'h00);

    // R4 R5 R6 R7 vector table
    foreach (VEC[i]) begin
      int h;
      h = (int'(VEC[i][22:20]) + 1) << VEC[i][18:16];
      xfer(VEC[i][26], VEC[i][25], VEC[i][24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], cyc);
      check("R4 cycles", cyc, 16*h + 1);
      check("R5 R6 slave rx", sl_rx, VEC[i][15:8]);
      br(5'h05, d); check("R7 stat", d, 8'h80);
      br(5'h09, d); check("R5 R6 master rx", d, VEC[i][7:0]);
      @(negedge clk); check("R7 irq cleared", irq_x, 0);
    end

    // R7 data read alone does not clear
    xfer(0, 0, 0, 8'h00, 8'h11, 8'h22, cyc);
    br(5'h09, d); @(negedge clk); check("R7 still set", irq_x, 1);
    br(5'h05, d); br(5'h09, d); @(negedge clk); check("R7 cleared", irq_x, 0);

    // R8 collision
    bw(5'h00, 8'hD0); bw(5'h04, 8'h02);
    sl_start(0, 0, 8'h00);
    bw(5'h09, 8'hC3);
    repeat (10) @(negedge clk);
    bw(5'h09, 8'h00);
    cyc = 0;
    while (!irq_x && cyc < 5000) begin @(negedge clk); cyc++; end
    sl_en = 0;
    check("R8 byte intact", sl_rx, 8'hC3);
    br(5'h05, d); check("R8 wcol flag", d, 8'hC0);
    br(5'h09, d); br(5'h05, d); check("R8 flags cleared", d, 8'h00);

    // R9 mode fault
    bw(5'h00, 8'hD0); bw(5'h04, 8'h03);
    sl_start(0, 0, 8'h00);
    bw(5'h09, 8'hAA);
    repeat (20) @(negedge clk);
    ss_in_n = 0;
    repeat (2) @(negedge clk);
    sl_en = 0;
    br(5'h00, d); check("R9 ctrl cleared", d, 8'h80);
    br(5'h05, d); check("R9 modf flag", d, 8'h10);
    check("R9 irq_modf", irq_m, 1);
    repeat (200) @(negedge clk);
    check("R9 no completion", irq_x, 0);
    check("R9 sck idle", sck, 0);
    ss_in_n = 1;
    bw(5'h00, 8'hD0); @(negedge clk);
    check("R9 modf cleared", irq_m, 0);
    br(5'h05, d); check("R9 stat clear", d, 8'h00);

    // R10 output-enable masks fault
    bw(5'h00, 8'hD2); ss_in_n = 0;
    repeat (3) @(negedge clk);
    br(5'h00, d); check("R10 ctrl kept", d, 8'hD2);
    br(5'h05, d); check("R10 no fault", d, 8'h00);
    ss_in_n = 1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule